// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps count of the flow-control credits that the far end of a link has granted to a transaction-layer transmitter on one virtual channel, and hands the application a compact 22-bit status word so it can decide which packet type to send, or how to split a large write, before asking for transmission. Three packet classes are tracked (posted, non-posted, completion), each with a header credit count and a data credit count. One data credit covers 16 bytes of payload.

The counters are loaded from an initial advertisement, which can mark any counter as unlimited. A credit-return strobe raises the limit of one class. An acknowledge strobe for an accepted packet, carrying its class and payload byte count, consumes one header credit and the rounded-up number of data credits. Each counter is kept as a limit and a consumed total, and the free amount is their difference taken modulo the counter width. The status word is computed from registered state, so it shows an acknowledge on the cycle after the acknowledge is sampled.

Top module: `fc_credit_tracker`

## Requirements
- R1: While reset is held, and after reset until the first initial load, every bit of `cred_out` is 0.
- R2: A cycle with `init_load` high sets the limits from `init_hdr`/`init_dat` (class 0 posted, 1 non-posted, 2 completion, each in its own slice), clears the consumed totals and loads the unlimited flags from `init_inf` (bit 2c for the header of class c, bit 2c+1 for its data). A load has priority over a return or an acknowledge in the same cycle, and both of those are then dropped.
- R3: An acknowledge consumes one header credit and ceil(`ack_len`/16) data credits from the class given by `ack_type`. A zero length consumes no data credit.
- R4: The effect of an acknowledge, return or load sampled at a clock edge appears on `cred_out` right after that edge and not before it. With none of the three strobes high, `cred_out` holds its value.
- R5: Header credit flags are at bit 0 (posted), bit 10 (non-posted) and bit 12 (completion). Each flag is 1 when at least one header credit is free and 0 when none is.
- R6: Data counts are at bits [9:1] (posted) and [21:13] (completion). Each field gives the free data credits, saturated at 256, so the codes 257 to 511 never appear.
- R7: Bit 11 is 1 when at least one non-posted data credit is free and 0 otherwise.
- R8: A counter advertised as unlimited shows its highest legal code (flag 1, count 256) and is never decremented by acknowledges.
- R9: A return on class `ret_type` adds `ret_hdr` and `ret_dat` to that class's limits. A return and an acknowledge on the same class in the same cycle are both applied.
- R10: Header counters are 8 bits and data counters 12 bits wide. The free amount is (limit - consumed) modulo the width, so a limit that wraps past the top of its range still yields the right free amount.
- R11: An acknowledge on a finite counter must not need more credit than is free. An acknowledge that uses exactly the remaining credit is legal and leaves the field at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_load | input | 1 | Load the initial advertisement |
| init_hdr | input | 24 | Initial header limits, 8 bits per class |
| init_dat | input | 36 | Initial data limits, 12 bits per class |
| init_inf | input | 6 | Unlimited flags, header and data per class |
| ret_valid | input | 1 | Credit return strobe |
| ret_type | input | 2 | Class of the return |
| ret_hdr | input | 8 | Header credits returned |
| ret_dat | input | 12 | Data credits returned |
| ack | input | 1 | Packet acknowledge strobe |
| ack_type | input | 2 | Class of the acknowledged packet |
| ack_len | input | 13 | Payload length in bytes |
| cred_out | output | 22 | Encoded free-credit status |

## Verification
The posted class receives payload lengths of zero, one byte, exact multiples of 16 and one byte over a multiple. These show whether the rounding to whole credits is right. Posted data is first left above 256 and later drawn below it, which separates the saturated code from the true count. A return and an acknowledge on the same class in the same cycle, and a load that coincides with an acknowledge, show whether the priority and merging rules hold. A data limit pushed past 4095 shows whether the subtraction is modular. A run with every counter unlimited shows whether traffic can still reduce a field that must stay pinned at its highest code.

// File: rtl/fc_credit_pkg.sv
package fc_credit_pkg;

    localparam int FC_NUM_TYPES = 3;
    localparam int FC_TYPE_W    = 2;

    typedef enum logic [FC_TYPE_W-1:0] {
        FC_POSTED    = 2'd0,
        FC_NONPOSTED = 2'd1,
        FC_COMPL     = 2'd2
    } fc_type_e;

endpackage

// File: rtl/fc_credit_counter.sv
module fc_credit_counter #(
    parameter int HDR_W        = 8,
    parameter int DAT_W        = 12,
    parameter int LEN_W        = 13,
    parameter int CREDIT_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_load,
    input  logic [HDR_W-1:0] init_hdr,
    input  logic [DAT_W-1:0] init_dat,
    input  logic             init_hdr_inf,
    input  logic             init_dat_inf,
    input  logic             ret_hit,
    input  logic [HDR_W-1:0] ret_hdr,
    input  logic [DAT_W-1:0] ret_dat,
    input  logic             ack_hit,
    input  logic [LEN_W-1:0] ack_len,
    output logic [HDR_W-1:0] hdr_avail,
    output logic [DAT_W-1:0] dat_avail,
    output logic             hdr_inf,
    output logic             dat_inf
);

    localparam int RND_W = LEN_W + 1;
    localparam logic [RND_W-1:0] RND_ADD = RND_W'((1 << CREDIT_SHIFT) - 1);

    typedef struct packed {
        logic [HDR_W-1:0] hdr_lim;
        logic [HDR_W-1:0] hdr_used;
        logic [DAT_W-1:0] dat_lim;
        logic [DAT_W-1:0] dat_used;
        logic             hdr_inf;
        logic             dat_inf;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [RND_W-1:0] len_rnd;
    logic [DAT_W-1:0] need;

    always_comb begin
        len_rnd = {1'b0, ack_len} + RND_ADD;
        need    = DAT_W'(len_rnd >> CREDIT_SHIFT);
        st_d    = st_q;
        if (init_load) begin
            st_d.hdr_lim  = init_hdr;
            st_d.dat_lim  = init_dat;
            st_d.hdr_used = '0;
            st_d.dat_used = '0;
            st_d.hdr_inf  = init_hdr_inf;
            st_d.dat_inf  = init_dat_inf;
        end else begin
            if (ret_hit) begin
                st_d.hdr_lim = st_q.hdr_lim + ret_hdr;
                st_d.dat_lim = st_q.dat_lim + ret_dat;
            end
            if (ack_hit) begin
                if (!st_q.hdr_inf) st_d.hdr_used = st_q.hdr_used + HDR_W'(1);
                if (!st_q.dat_inf) st_d.dat_used = st_q.dat_used + need;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_avail = st_q.hdr_lim - st_q.hdr_used;
    assign dat_avail = st_q.dat_lim - st_q.dat_used;
    assign hdr_inf   = st_q.hdr_inf;
    assign dat_inf   = st_q.dat_inf;

endmodule

// File: rtl/fc_flag_enc.sv
module fc_flag_enc #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] avail,
    input  logic             inf,
    output logic             flag
);

    always_comb flag = inf | (|avail);

endmodule

// File: rtl/fc_count_enc.sv
module fc_count_enc #(
    parameter int CNT_W = 12,
    parameter int FLD_W = 9
) (
    input  logic [CNT_W-1:0] avail,
    input  logic             inf,
    output logic [FLD_W-1:0] field
);

    localparam int FLD_MAX = 1 << (FLD_W - 1);
    localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(FLD_MAX);
    localparam logic [FLD_W-1:0] CAP_FLD = FLD_W'(FLD_MAX);

    always_comb begin
        if (inf || (avail > CAP_CNT)) field = CAP_FLD;
        else                          field = FLD_W'(avail);
    end

endmodule

// File: rtl/fc_credit_tracker.sv
module fc_credit_tracker
    import fc_credit_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12,
    parameter int LEN_W = 13,
    parameter int FLD_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init_load,
    input  logic [FC_NUM_TYPES*HDR_W-1:0] init_hdr,
    input  logic [FC_NUM_TYPES*DAT_W-1:0] init_dat,
    input  logic [2*FC_NUM_TYPES-1:0]     init_inf,
    input  logic                          ret_valid,
    input  logic [FC_TYPE_W-1:0]          ret_type,
    input  logic [HDR_W-1:0]              ret_hdr,
    input  logic [DAT_W-1:0]              ret_dat,
    input  logic                          ack,
    input  logic [FC_TYPE_W-1:0]          ack_type,
    input  logic [LEN_W-1:0]              ack_len,
    output logic [2*FLD_W+3:0]            cred_out
);

    localparam int CREDIT_SHIFT = 4;

    logic [FC_NUM_TYPES-1:0][HDR_W-1:0] hdr_avail;
    logic [FC_NUM_TYPES-1:0][DAT_W-1:0] dat_avail;
    logic [FC_NUM_TYPES-1:0]            hdr_inf;
    logic [FC_NUM_TYPES-1:0]            dat_inf;
    logic [FC_NUM_TYPES-1:0]            hdr_flag;
    logic                               np_dat_flag;
    logic [FLD_W-1:0]                   p_dat_fld;
    logic [FLD_W-1:0]                   c_dat_fld;

    for (genvar t = 0; t < FC_NUM_TYPES; t++) begin : g_type
        logic ret_hit;
        logic ack_hit;
        assign ret_hit = ret_valid && (ret_type == FC_TYPE_W'(t));
        assign ack_hit = ack && (ack_type == FC_TYPE_W'(t));

        fc_credit_counter #(
            .HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W), .CREDIT_SHIFT(CREDIT_SHIFT)
        ) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .init_load    (init_load),
            .init_hdr     (init_hdr[t*HDR_W +: HDR_W]),
            .init_dat     (init_dat[t*DAT_W +: DAT_W]),
            .init_hdr_inf (init_inf[2*t]),
            .init_dat_inf (init_inf[2*t+1]),
            .ret_hit      (ret_hit),
            .ret_hdr      (ret_hdr),
            .ret_dat      (ret_dat),
            .ack_hit      (ack_hit),
            .ack_len      (ack_len),
            .hdr_avail    (hdr_avail[t]),
            .dat_avail    (dat_avail[t]),
            .hdr_inf      (hdr_inf[t]),
            .dat_inf      (dat_inf[t])
        );

        fc_flag_enc #(.CNT_W(HDR_W)) u_hdr_enc (
            .avail (hdr_avail[t]),
            .inf   (hdr_inf[t]),
            .flag  (hdr_flag[t])
        );
    end

    fc_count_enc #(.CNT_W(DAT_W), .FLD_W(FLD_W)) u_p_dat_enc (
        .avail (dat_avail[FC_POSTED]),
        .inf   (dat_inf[FC_POSTED]),
        .field (p_dat_fld)
    );

    fc_flag_enc #(.CNT_W(DAT_W)) u_np_dat_enc (
        .avail (dat_avail[FC_NONPOSTED]),
        .inf   (dat_inf[FC_NONPOSTED]),
        .flag  (np_dat_flag)
    );

    fc_count_enc #(.CNT_W(DAT_W), .FLD_W(FLD_W)) u_c_dat_enc (
        .avail (dat_avail[FC_COMPL]),
        .inf   (dat_inf[FC_COMPL]),
        .field (c_dat_fld)
    );

    assign cred_out = {c_dat_fld, hdr_flag[FC_COMPL], np_dat_flag,
                       hdr_flag[FC_NONPOSTED], p_dat_fld, hdr_flag[FC_POSTED]};

endmodule

// File: rtl/fc_credit_checker.sv
module fc_credit_checker #(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12,
    parameter int LEN_W = 13,
    parameter int FLD_W = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  init_load,
    input logic [5:0]            init_inf,
    input logic                  ret_valid,
    input logic [1:0]            ret_type,
    input logic                  ack,
    input logic [1:0]            ack_type,
    input logic [LEN_W-1:0]      ack_len,
    input logic [2*FLD_W+3:0]    cred_out,
    input logic [2:0][HDR_W-1:0] hdr_avail,
    input logic [2:0][DAT_W-1:0] dat_avail,
    input logic [2:0]            hdr_inf,
    input logic [2:0]            dat_inf
);

    localparam int CAP = 1 << (FLD_W - 1);

    logic             loaded_q;
    logic [DAT_W-1:0] ack_need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         loaded_q <= 1'b0;
        else if (init_load) loaded_q <= 1'b1;
    end

    always_comb ack_need = DAT_W'((32'(ack_len) + 32'd15) / 32'd16);

    // R1: nothing is reported before the first load
    assert_zero_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_q |-> (cred_out == '0));

    // R6: reserved count codes never leave the block
    assert_no_reserved_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cred_out[FLD_W:1]) <= CAP) && (int'(cred_out[2*FLD_W+3:FLD_W+4]) <= CAP));

    // R4: no strobe, no change
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_load && !ack && !ret_valid) |=> $stable(cred_out));

    // R8: posted data advertised unlimited shows the top code on the next cycle
    assert_unlimited_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_load && init_inf[1]) |=> (int'(cred_out[FLD_W:1]) == CAP));

    for (genvar t = 0; t < 3; t++) begin : g_chk
        // R11: an acknowledge never overdraws a finite counter
        assert_no_overdraw_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && !init_load && (ack_type == 2'(t))) |->
                ((hdr_inf[t] || (hdr_avail[t] != '0)) &&
                 (dat_inf[t] || (dat_avail[t] >= ack_need))));

        // R3 / R4: the free data amount drops by the rounded length one cycle later
        assert_data_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && (ack_type == 2'(t)) && !dat_inf[t] && !init_load &&
             !(ret_valid && (ret_type == 2'(t))))
            |=> (dat_avail[t] == DAT_W'($past(dat_avail[t]) - $past(ack_need))));

        // R8: unlimited counters keep their flag until the next load
        assert_unlimited_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (dat_inf[t] && !init_load) |=> dat_inf[t]);
    end

endmodule

bind fc_credit_tracker fc_credit_checker #(
    .HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W), .FLD_W(FLD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_load (init_load),
    .init_inf  (init_inf),
    .ret_valid (ret_valid),
    .ret_type  (ret_type),
    .ack       (ack),
    .ack_type  (ack_type),
    .ack_len   (ack_len),
    .cred_out  (cred_out),
    .hdr_avail (hdr_avail),
    .dat_avail (dat_avail),
    .hdr_inf   (hdr_inf),
    .dat_inf   (dat_inf)
);

// File: tb/fc_credit_tracker_tb.sv
module fc_credit_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        init_load = 1'b0;
    logic [23:0] init_hdr = '0;
    logic [35:0] init_dat = '0;
    logic [5:0]  init_inf = '0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_type = '0;
    logic [7:0]  ret_hdr = '0;
    logic [11:0] ret_dat = '0;
    logic        ack = 1'b0;
    logic [1:0]  ack_type = '0;
    logic [12:0] ack_len = '0;
    logic [21:0] cred_out;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int hlim[3] = '{0, 0, 0};
    int hused[3] = '{0, 0, 0};
    int dlim[3] = '{0, 0, 0};
    int dused[3] = '{0, 0, 0};
    bit hinf[3] = '{0, 0, 0};
    bit dinf[3] = '{0, 0, 0};

    always #4 clk = ~clk;

    fc_credit_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_hdr(init_hdr),
        .init_dat(init_dat), .init_inf(init_inf), .ret_valid(ret_valid),
        .ret_type(ret_type), .ret_hdr(ret_hdr), .ret_dat(ret_dat), .ack(ack),
        .ack_type(ack_type), .ack_len(ack_len), .cred_out(cred_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < 3; t++) begin
                hlim[t] = 0; hused[t] = 0; dlim[t] = 0; dused[t] = 0;
                hinf[t] = 0; dinf[t] = 0;
            end
        end else if (init_load) begin
            for (int t = 0; t < 3; t++) begin
                hlim[t] = int'(init_hdr[t*8 +: 8]);
                dlim[t] = int'(init_dat[t*12 +: 12]);
                hused[t] = 0; dused[t] = 0;
                hinf[t] = init_inf[2*t]; dinf[t] = init_inf[2*t+1];
            end
        end else begin
            if (ret_valid && ret_type < 2'd3) begin
                hlim[ret_type] = (hlim[ret_type] + int'(ret_hdr)) % 256;
                dlim[ret_type] = (dlim[ret_type] + int'(ret_dat)) % 4096;
            end
            if (ack && ack_type < 2'd3) begin
                if (!hinf[ack_type]) hused[ack_type] = (hused[ack_type] + 1) % 256;
                if (!dinf[ack_type])
                    dused[ack_type] = (dused[ack_type] + (int'(ack_len) + 15) / 16) % 4096;
            end
        end
    end

    function automatic int h_free(int t);
        return ((hlim[t] - hused[t]) % 256 + 256) % 256;
    endfunction

    function automatic int d_free(int t);
        return ((dlim[t] - dused[t]) % 4096 + 4096) % 4096;
    endfunction

    function automatic logic [8:0] d_code(int t);
        if (dinf[t] || d_free(t) > 256) return 9'd256;
        return 9'(d_free(t));
    endfunction

    function automatic logic [21:0] exp_word();
        logic [21:0] e;
        e[0]     = hinf[0] || h_free(0) != 0;
        e[9:1]   = d_code(0);
        e[10]    = hinf[1] || h_free(1) != 0;
        e[11]    = dinf[1] || d_free(1) != 0;
        e[12]    = hinf[2] || h_free(2) != 0;
        e[21:13] = d_code(2);
        return e;
    endfunction

    task automatic chk(string req, logic [21:0] act, logic [21:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the reference on every cycle
    always @(negedge clk) if (live) chk(cur_req, cred_out, exp_word());

    task automatic set_init(int ph, int pd, int nph, int npd, int ch, int cd, logic [5:0] inf);
        init_load = 1'b1;
        init_hdr  = {8'(ch), 8'(nph), 8'(ph)};
        init_dat  = {12'(cd), 12'(npd), 12'(pd)};
        init_inf  = inf;
    endtask

    task automatic set_ack(int t, int len);
        ack = 1'b1; ack_type = 2'(t); ack_len = 13'(len);
    endtask

    task automatic set_ret(int t, int h, int d);
        ret_valid = 1'b1; ret_type = 2'(t); ret_hdr = 8'(h); ret_dat = 12'(d);
    endtask

    task automatic step();
        @(negedge clk);
        init_load = 1'b0; ack = 1'b0; ret_valid = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        live = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", cred_out, 22'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", cred_out, 22'd0);

        // R2: load, posted data above the cap
        cur_req = "R2";
        set_init(3, 300, 2, 5, 1, 20, 6'b0);
        step();
        chk("R2", cred_out, {9'd20, 1'b1, 1'b1, 1'b1, 9'd256, 1'b1});
        chk("R6", 22'(cred_out[9:1]), 22'd256);

        // R3 / R5: three posted packets use all posted header credit
        cur_req = "R3";
        set_ack(0, 17); step();
        set_ack(0, 1);  step();
        set_ack(0, 0);  step();
        chk("R5", 22'(cred_out[0]), 22'd0);
        cur_req = "R9";
        set_ret(0, 10, 0); step();
        chk("R5", 22'(cred_out[0]), 22'd1);
        cur_req = "R3";
        set_ack(0, 1024); step();
        chk("R3", 22'(cred_out[9:1]), 22'd233);

        // R4: unchanged before the edge, changed right after it
        cur_req = "R4";
        set_ack(0, 160);
        chk("R4", 22'(cred_out[9:1]), 22'd233);
        step();
        chk("R4", 22'(cred_out[9:1]), 22'd223);
        repeat (2) step();
        chk("R4", 22'(cred_out[9:1]), 22'd223);
        cur_req = "R3";
        set_ack(0, 33); step();
        chk("R3", 22'(cred_out[9:1]), 22'd220);

        // R9: return and acknowledge on the same class together
        cur_req = "R9";
        set_ack(0, 32); set_ret(0, 0, 5); step();
        chk("R9", 22'(cred_out[9:1]), 22'd223);
        set_ack(1, 4); set_ret(1, 1, 1); step();
        chk("R9", 22'(cred_out[11:10]), 22'b11);

        // R7: non-posted data drained
        cur_req = "R7";
        set_ack(1, 80); step();
        chk("R7", 22'(cred_out[11]), 22'd0);
        chk("R5", 22'(cred_out[10]), 22'd1);

        // R11: completion drained exactly
        cur_req = "R11";
        set_ack(2, 320); step();
        chk("R11", 22'(cred_out[21:12]), 22'd0);
        chk("R6", 22'(cred_out[21:13]), 22'd0);

        // R10: data limit wraps past 4095
        cur_req = "R10";
        set_init(5, 4095, 0, 0, 0, 0, 6'b0); step();
        set_ack(0, 64); step();
        chk("R10", 22'(cred_out[9:1]), 22'd256);
        set_ret(0, 0, 10); step();
        chk("R10", 22'(cred_out[9:1]), 22'd5);

        // R8: all unlimited, traffic leaves the word pinned
        cur_req = "R8";
        set_init(0, 0, 0, 0, 0, 0, 6'h3f); step();
        chk("R8", cred_out, {9'd256, 1'b1, 1'b1, 1'b1, 9'd256, 1'b1});
        for (int i = 0; i < 6; i++) begin
            set_ack(i % 3, 4096); step();
        end
        chk("R8", cred_out, {9'd256, 1'b1, 1'b1, 1'b1, 9'd256, 1'b1});

        // R2: load wins over a simultaneous acknowledge
        cur_req = "R2";
        set_init(2, 40, 1, 1, 1, 8, 6'b0); set_ack(0, 160); step();
        chk("R2", cred_out, {9'd8, 1'b1, 1'b1, 1'b1, 9'd40, 1'b1});
        repeat (3) step();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule